// File: doc/BRIEF.md
# Operand Bypass Selector for an In-Order Integer Pipeline

This block picks, for each ALU source of the instruction now entering the execute stage, where that operand comes from. It can come from the register file, from the result held in the execute/memory pipeline register, or from the result held in the memory/writeback pipeline register. It compares the two source register numbers against the destination field, valid flag and write flag of both of those pipeline registers. The youngest older instruction that really writes the register wins. The register file is written early in a cycle and read late in it, so a value in writeback is already visible to the decode read, and no third bypass level exists.

The block also drives a separate select for the data of a store that sits in the memory stage. When the instruction just ahead of that store, now in writeback, is a load that writes the register the store reads, the loaded word is steered into the store data. This removes the stall for that pattern. The logic is purely combinational and its outputs drive the operand multiplexers directly.

Top module: `fwd_unit`

## Requirements
- R1: An operand selects code 01 (execute/memory result) when that stage holds a valid, register-writing, non-load instruction whose destination equals the operand's source number and is not register 0.
- R2: An operand selects code 10 (memory/writeback result) when the memory/writeback stage holds a valid, register-writing instruction whose destination equals the source and is not register 0, and the execute/memory stage holds no valid writer of that register.
- R3: When both stages hold valid writers of the same source register, the execute/memory stage is chosen (code 01).
- R4: A stage whose valid flag is low, or whose write flag is low, is never a source, whatever its destination number.
- R5: A source number of 0 always selects code 00 (register file), even when a stage names register 0 as its destination.
- R6: When the execute/memory stage holds a valid load that writes the source register, that operand selects code 00. An older matching writer in memory/writeback is not used, and resolving the hazard is left to a stall unit.
- R7: The two ALU operands are resolved independently, so each may take a different code in the same cycle.
- R8: The store-data select is 1 only when the execute/memory stage holds a valid store, and the memory/writeback stage holds a valid, register-writing load whose destination equals the store's data register and is not register 0. Otherwise it is 0.
- R9: With no qualifying match an operand selects code 00, and code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | RW | First ALU source register number of the instruction entering execute |
| ex_rs2 | input | RW | Second ALU source register number of the instruction entering execute |
| exm_valid | input | 1 | Execute/memory register holds a live instruction |
| exm_wen | input | 1 | Execute/memory instruction writes a register |
| exm_load | input | 1 | Execute/memory instruction is a load |
| exm_store | input | 1 | Execute/memory instruction is a store |
| exm_rd | input | RW | Execute/memory destination register number |
| exm_st_rs | input | RW | Register supplying the store data of the execute/memory instruction |
| mwb_valid | input | 1 | Memory/writeback register holds a live instruction |
| mwb_wen | input | 1 | Memory/writeback instruction writes a register |
| mwb_load | input | 1 | Memory/writeback instruction is a load |
| mwb_rd | input | RW | Memory/writeback destination register number |
| fwd_a | output | 2 | First operand select: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | Second operand select, same coding |
| st_fwd | output | 1 | Store data taken from the memory/writeback load result |

## Verification
The bench drives both stages with the same destination to confirm the younger one wins. A reversed priority would return code 10 and feed a stale value. It names register 0 in every field to catch a design that forwards a result to the hardwired zero. It also clears only the valid flag or only the write flag while keeping the destination matched, which exposes a design that forwards from a flushed bubble or a non-writing instruction. Finally, it places a load in execute/memory over a matching writer in memory/writeback, and a non-load or zero-destination instruction ahead of a store. A design that bypasses a not-yet-loaded value, or steers store data from the wrong producer, then shows a wrong select.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic          exm_valid,
  input  logic          exm_wen,
  input  logic          exm_load,
  input  logic          exm_store,
  input  logic [RW-1:0] exm_rd,
  input  logic [RW-1:0] exm_st_rs,
  input  logic          mwb_valid,
  input  logic          mwb_wen,
  input  logic          mwb_load,
  input  logic [RW-1:0] mwb_rd,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd
);

  localparam logic [1:0]    SEL_RF   = 2'b00;
  localparam logic [1:0]    SEL_EXM  = 2'b01;
  localparam logic [1:0]    SEL_MWB  = 2'b10;
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic exm_src, mwb_src;
  logic a_exm_hit, a_mwb_hit, b_exm_hit, b_mwb_hit;

  assign exm_src = exm_valid && exm_wen && (exm_rd != ZERO_REG);
  assign mwb_src = mwb_valid && mwb_wen && (mwb_rd != ZERO_REG);

  assign a_exm_hit = exm_src && (exm_rd == ex_rs1);
  assign a_mwb_hit = mwb_src && (mwb_rd == ex_rs1);
  assign b_exm_hit = exm_src && (exm_rd == ex_rs2);
  assign b_mwb_hit = mwb_src && (mwb_rd == ex_rs2);

  assign fwd_a = a_exm_hit ? (exm_load ? SEL_RF : SEL_EXM)
               : a_mwb_hit ? SEL_MWB : SEL_RF;
  assign fwd_b = b_exm_hit ? (exm_load ? SEL_RF : SEL_EXM)
               : b_mwb_hit ? SEL_MWB : SEL_RF;

  assign st_fwd = exm_valid && exm_store && mwb_src && mwb_load
               && (mwb_rd == exm_st_rs);

  always_comb begin
    // R9
    code_legal_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    // R4
    exm_live_chk: assert (!(fwd_a == SEL_EXM || fwd_b == SEL_EXM) || (exm_valid && exm_wen));
    // R4
    mwb_live_chk: assert (!(fwd_a == SEL_MWB || fwd_b == SEL_MWB) || (mwb_valid && mwb_wen));
    // R5
    zero_reg_chk: assert ((ex_rs1 != ZERO_REG || fwd_a == SEL_RF) && (ex_rs2 != ZERO_REG || fwd_b == SEL_RF));
    // R6
    load_hold_chk: assert (!(exm_valid && exm_wen && exm_load && exm_rd == ex_rs1) || fwd_a == SEL_RF);
    // R8
    store_src_chk: assert (!st_fwd || (exm_store && mwb_load && mwb_valid && mwb_rd != ZERO_REG));
  end

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0] ex_rs1, ex_rs2, exm_rd, exm_st_rs, mwb_rd;
  logic exm_valid, exm_wen, exm_load, exm_store, mwb_valid, mwb_wen, mwb_load;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  fwd_unit #(.RW(RW)) dut (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .exm_valid(exm_valid), .exm_wen(exm_wen), .exm_load(exm_load),
    .exm_store(exm_store), .exm_rd(exm_rd), .exm_st_rs(exm_st_rs),
    .mwb_valid(mwb_valid), .mwb_wen(mwb_wen), .mwb_load(mwb_load), .mwb_rd(mwb_rd),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd)
  );

  task automatic clear();
    ex_rs1 = '0; ex_rs2 = '0; exm_rd = '0; exm_st_rs = '0; mwb_rd = '0;
    exm_valid = 0; exm_wen = 0; exm_load = 0; exm_store = 0;
    mwb_valid = 0; mwb_wen = 0; mwb_load = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic exm_set(input int rd, input bit ld);
    exm_valid = 1; exm_wen = 1; exm_load = ld; exm_rd = RW'(rd);
  endtask

  task automatic mwb_set(input int rd, input bit ld);
    mwb_valid = 1; mwb_wen = 1; mwb_load = ld; mwb_rd = RW'(rd);
  endtask

  task automatic t_idle();
    clear(); ex_rs1 = 5'd3; ex_rs2 = 5'd4; settle();
    chk("R9 idle a", fwd_a, 0);
    chk("R9 idle b", fwd_b, 0);
    chk("R9 idle st", st_fwd, 0);
  endtask

  task automatic t_exm();
    clear(); exm_set(3, 0); ex_rs1 = 5'd3; ex_rs2 = 5'd4; settle();
    chk("R1 exm a", fwd_a, 1);
    chk("R1 exm other b", fwd_b, 0);
  endtask

  task automatic t_mwb();
    clear(); mwb_set(4, 0); ex_rs1 = 5'd2; ex_rs2 = 5'd4; settle();
    chk("R2 mwb b", fwd_b, 2);
    chk("R2 mwb other a", fwd_a, 0);
  endtask

  task automatic t_prio();
    clear(); exm_set(5, 0); mwb_set(5, 0); ex_rs1 = 5'd5; ex_rs2 = 5'd5; settle();
    chk("R3 prio a", fwd_a, 1);
    chk("R3 prio b", fwd_b, 1);
  endtask

  task automatic t_invalid();
    clear(); exm_set(6, 0); mwb_set(6, 0); exm_valid = 0; mwb_valid = 0;
    ex_rs1 = 5'd6; ex_rs2 = 5'd6; settle();
    chk("R4 both invalid a", fwd_a, 0);
    chk("R4 both invalid b", fwd_b, 0);
    mwb_valid = 1; settle();
    chk("R4 exm invalid falls to mwb", fwd_a, 2);
    clear(); exm_set(6, 0); mwb_set(6, 0); exm_wen = 0; mwb_wen = 0;
    ex_rs1 = 5'd6; settle();
    chk("R4 no write a", fwd_a, 0);
    mwb_wen = 1; settle();
    chk("R4 exm nowrite falls to mwb", fwd_a, 2);
  endtask

  task automatic t_zero();
    clear(); exm_set(0, 0); mwb_set(0, 0); ex_rs1 = 5'd0; ex_rs2 = 5'd0; settle();
    chk("R5 zero a", fwd_a, 0);
    chk("R5 zero b", fwd_b, 0);
  endtask

  task automatic t_load();
    clear(); exm_set(7, 1); mwb_set(7, 0); ex_rs1 = 5'd7; ex_rs2 = 5'd7; settle();
    chk("R6 load exm a", fwd_a, 0);
    chk("R6 load exm b", fwd_b, 0);
    mwb_rd = 5'd8; ex_rs2 = 5'd8; settle();
    chk("R6 other operand mwb b", fwd_b, 2);
  endtask

  task automatic t_both();
    clear(); exm_set(1, 0); mwb_set(2, 0); ex_rs1 = 5'd1; ex_rs2 = 5'd2; settle();
    chk("R7 split a", fwd_a, 1);
    chk("R7 split b", fwd_b, 2);
    ex_rs1 = 5'd2; ex_rs2 = 5'd1; settle();
    chk("R7 swap a", fwd_a, 2);
    chk("R7 swap b", fwd_b, 1);
  endtask

  task automatic t_store();
    clear(); exm_valid = 1; exm_store = 1; exm_st_rs = 5'd9; mwb_set(9, 1); settle();
    chk("R8 load to store", st_fwd, 1);
    mwb_load = 0; settle();
    chk("R8 non-load producer", st_fwd, 0);
    mwb_load = 1; mwb_valid = 0; settle();
    chk("R8 invalid load", st_fwd, 0);
    mwb_valid = 1; exm_store = 0; settle();
    chk("R8 not a store", st_fwd, 0);
    exm_store = 1; mwb_rd = 5'd10; settle();
    chk("R8 other register", st_fwd, 0);
    mwb_rd = 5'd0; exm_st_rs = 5'd0; settle();
    chk("R8 register zero", st_fwd, 0);
    mwb_rd = 5'd9; exm_st_rs = 5'd9; mwb_wen = 0; settle();
    chk("R8 load not writing", st_fwd, 0);
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    rst = 0;
    t_idle();
    t_exm();
    t_mwb();
    t_prio();
    t_invalid();
    t_zero();
    t_load();
    t_both();
    t_store();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule